// File: doc/BRIEF.md
# Center-aligned three-phase PWM generator

This block drives three complementary switch pairs, one per motor phase, from a single up/down timebase. Every period has two half-cycles. The counter rises through the first half and falls back through the second. Each phase compares the counter with its own duty value to place a high-side pulse that straddles the center of the period, and a low-side pulse that sits at its ends. A programmable dead time pulls every switching edge inward by the same number of ticks, so a high and a low output are never on together, and the pulses stay centered in the period.

Software writes the period, the three duty values, the dead time and the sync width through a one-word write port. The writes go into shadow registers. In single-update mode the shadow values move to the active set once per period, at the period start. In double-update mode they also move at the midpoint, so the period, the duty values and the dead time can differ between the two halves. The block also provides a sync pulse at each period start and a flag that shows the active half-cycle. It keeps all outputs off until the period and all three duty values have each been written at least once.

Top module: `pwm3_center`

## Requirements
- R1: Once running, each half-cycle lasts as many ticks as the active period value, which must be at least 1. `half_o` is 0 during the first half and 1 during the second. The first half starts on the clock edge after the counter is released.
- R2: Let the per-half high time be `duty − dead`, clamped as in R4. The high-side output is on for the last high-time ticks of the first half and the first high-time ticks of the second half. Let the per-half low time be `period − duty − dead`. The low-side output is on for the first low-time ticks of the first half and the last low-time ticks of the second half.
- R3: The high-side and low-side outputs of the same phase are never on in the same cycle.
- R4: A per-half on-time that comes out negative is treated as 0. A high time larger than the half-cycle length is limited to that length.
- R5: `sync_o` is on for the first `min(sync width + 1, period)` ticks of each period. It is never on in the second half.
- R6: A write with `wr_en` high stores `wr_data` in a shadow register chosen by `wr_addr`: 0 period, 1 duty A, 2 duty B, 3 duty C, 4 dead time, 5 sync width. All outputs remain 0 and the counter stays idle until addresses 0, 1, 2 and 3 have each been written since reset.
- R7: With `dbl_mode` low, the shadow values become active only at the start of a period. A write made during a period has no effect on the rest of that period.
- R8: With `dbl_mode` high at the midpoint, the shadow values also become active at the start of the second half. A new period value there sets the length of the second half.
- R9: While `rst_n` is low, all six phase outputs, `sync_o` and `half_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbl_mode | input | 1 | 1 = also reload the active set at the midpoint |
| wr_en | input | 1 | Write strobe for the shadow registers |
| wr_addr | input | 3 | Shadow register select (see R6) |
| wr_data | input | CW | Value to write |
| a_hi | output | 1 | Phase A high-side drive |
| a_lo | output | 1 | Phase A low-side drive |
| b_hi | output | 1 | Phase B high-side drive |
| b_lo | output | 1 | Phase B low-side drive |
| c_hi | output | 1 | Phase C high-side drive |
| c_lo | output | 1 | Phase C low-side drive |
| sync_o | output | 1 | Period-start sync pulse |
| half_o | output | 1 | Active half-cycle (0 first, 1 second) |

## Verification
All outputs are decoded from registered state without a further register. Each tick's levels therefore appear just after the clock edge that enters that tick.

- A write reaches the shadow set on the edge that samples it.
- The counter is released on the next edge after the last required write, and the first tick follows one edge later.
- Reloads take effect in the first tick of the next period, or of the next half in double-update mode.

The bench queues one expected item per tick in the order the ticks will occur and compares them on falling edges. It places each write in the middle of a half-cycle, so every write lands at a known distance from the reload edge it is meant to hit or miss.

// File: rtl/pwm3_center.sv
module pwm3_center #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dbl_mode,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic          a_hi,
  output logic          a_lo,
  output logic          b_hi,
  output logic          b_lo,
  output logic          c_hi,
  output logic          c_lo,
  output logic          sync_o,
  output logic          half_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] sh_tm, sh_dt, sh_sw, act_tm, act_dt, act_sw, cnt;
  logic [CW-1:0] sh_duty [3];
  logic [CW-1:0] act_duty [3];
  logic [3:0]    seen;
  logic          run, half;
  logic [2:0]    hi, lo;

  wire mid_pt     = run && !half && (cnt == act_tm - ONE);
  wire start_pt   = (!run && &seen) || (run && half && cnt == '0);
  wire reload     = start_pt || (mid_pt && dbl_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_tm <= '0; sh_dt <= '0; sh_sw <= '0; seen <= '0;
      for (int i = 0; i < 3; i++) sh_duty[i] <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        3'd0: begin sh_tm <= wr_data; seen[0] <= 1'b1; end
        3'd1, 3'd2, 3'd3: begin
          sh_duty[wr_addr - 3'd1] <= wr_data;
          seen[wr_addr[1:0]] <= 1'b1;
        end
        3'd4: sh_dt <= wr_data;
        3'd5: sh_sw <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_tm <= '0; act_dt <= '0; act_sw <= '0;
      for (int i = 0; i < 3; i++) act_duty[i] <= '0;
    end else if (reload) begin
      act_tm <= sh_tm; act_dt <= sh_dt; act_sw <= sh_sw;
      for (int i = 0; i < 3; i++) act_duty[i] <= sh_duty[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; half <= 1'b0; cnt <= '0;
    end else if (!run) begin
      if (&seen) begin
        run <= 1'b1; half <= 1'b0; cnt <= '0;
      end
    end else if (!half) begin
      if (mid_pt) begin
        half <= 1'b1;
        if (dbl_mode) cnt <= sh_tm - ONE;
      end else begin
        cnt <= cnt + ONE;
      end
    end else if (cnt == '0) begin
      half <= 1'b0;
    end else begin
      cnt <= cnt - ONE;
    end
  end

  for (genvar g = 0; g < 3; g++) begin : g_phase
    logic [CW:0]   both;
    logic [CW-1:0] hraw, hon, lon;
    assign both = {1'b0, act_duty[g]} + {1'b0, act_dt};
    assign hraw = (act_duty[g] > act_dt) ? act_duty[g] - act_dt : '0;
    assign hon  = (hraw > act_tm) ? act_tm : hraw;
    assign lon  = ({1'b0, act_tm} > both) ? act_tm - act_duty[g] - act_dt : '0;
    assign hi[g] = run && (cnt >= act_tm - hon);
    assign lo[g] = run && (cnt < lon);
  end

  assign a_hi = hi[0];
  assign a_lo = lo[0];
  assign b_hi = hi[1];
  assign b_lo = lo[1];
  assign c_hi = hi[2];
  assign c_lo = lo[2];
  assign sync_o = run && !half && (cnt <= act_sw);
  assign half_o = half;
endmodule

module pwm3_center_chk #(
  parameter int CW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          half,
  input logic          dbl_mode,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] act_tm,
  input logic          a_hi, a_lo, b_hi, b_lo, c_hi, c_lo,
  input logic          sync_o,
  input logic          half_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  // R3
  no_shoot_a_chk: assert property (@(posedge clk) disable iff (!rst_n) !(a_hi && a_lo));
  // R3
  no_shoot_b_chk: assert property (@(posedge clk) disable iff (!rst_n) !(b_hi && b_lo));
  // R3
  no_shoot_c_chk: assert property (@(posedge clk) disable iff (!rst_n) !(c_hi && c_lo));
  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !(a_hi || a_lo || b_hi || b_lo || c_hi || c_lo || sync_o));
  // R1
  down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (half && $past(half)) |-> ((cnt + ONE) == $past(cnt)));
  // R5
  sync_first_chk: assert property (@(posedge clk) disable iff (!rst_n) sync_o |-> !half_o);
  // R7
  single_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && !$past(dbl_mode) && $rose(half)) |-> $stable(act_tm));
endmodule

bind pwm3_center pwm3_center_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .half(half), .dbl_mode(dbl_mode),
  .cnt(cnt), .act_tm(act_tm),
  .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo), .c_hi(c_hi), .c_lo(c_lo),
  .sync_o(sync_o), .half_o(half_o)
);

// File: tb/sim_pwm3_center.sv
module sim_pwm3_center;
  localparam int CW = 10;

  logic clk = 1'b0, rst_n = 1'b0, dbl_mode = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic a_hi, a_lo, b_hi, b_lo, c_hi, c_lo, sync_o, half_o;

  always #5 clk = ~clk;

  pwm3_center #(.CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .dbl_mode(dbl_mode), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo), .c_hi(c_hi), .c_lo(c_lo),
    .sync_o(sync_o), .half_o(half_o)
  );

  typedef struct {
    logic [7:0] v;
    string      tag;
  } item_t;

  item_t q[$];
  int nchk = 0, nerr = 0, pos = -1;
  bit done = 0;

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got=%b exp=%b at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [1:0] pair(int tm, int d, int dt, int h, int t);
    int hon = d - dt;
    int lon = tm - d - dt;
    if (hon < 0) hon = 0;
    if (hon > tm) hon = tm;
    if (lon < 0) lon = 0;
    if (h == 0) return {t >= tm - hon, t < lon};
    return {t < hon, t >= tm - lon};
  endfunction

  task automatic push_half(int tm, int a, int b, int c, int dt, int sw, int h, string tag);
    for (int t = 0; t < tm; t++) begin
      item_t it;
      it.v = {(h == 0 && t <= sw), h[0], pair(tm, a, dt, h, t),
              pair(tm, b, dt, h, t), pair(tm, c, dt, h, t)};
      it.tag = tag;
      q.push_back(it);
    end
  endtask

  task automatic wr(int addr, int data);
    wr_en = 1'b1; wr_addr = addr[2:0]; wr_data = data[CW-1:0];
    @(negedge clk);
    wr_en = 1'b0;
    pos++;
  endtask

  task automatic goto(int j);
    repeat (j - pos) @(negedge clk);
    pos = j;
  endtask

  function automatic logic [7:0] outs();
    return {sync_o, half_o, a_hi, a_lo, b_hi, b_lo, c_hi, c_lo};
  endfunction

  always @(negedge clk) begin
    item_t it;
    if (q.size() > 0) begin
      it = q.pop_front();
      chk(it.tag, {2'b00, a_hi, a_lo, b_hi, b_lo, c_hi, c_lo}, {2'b00, it.v[5:0]});
      chk("R5", {7'd0, sync_o}, {7'd0, it.v[7]});
      chk("R1", {7'd0, half_o}, {7'd0, it.v[6]});
      chk("R3", {7'd0, (a_hi & a_lo) | (b_hi & b_lo) | (c_hi & c_lo)}, 8'd0);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9", outs(), 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    wr(0, 10); wr(1, 6); wr(2, 3); wr(4, 2); wr(5, 2);
    repeat (4) @(negedge clk);
    chk("R6", outs(), 8'd0);
    wr(3, 1);
    chk("R6", outs(), 8'd0);
    #1;
    pos = -1;
    push_half(10, 6, 3, 1, 2, 2, 0, "R2");
    push_half(10, 6, 3, 1, 2, 2, 1, "R2");
    push_half(10, 6, 3, 1, 2, 2, 0, "R7");
    push_half(10, 6, 3, 1, 2, 2, 1, "R7");
    push_half(10, 9, 3, 1, 2, 2, 0, "R4");
    push_half(10, 9, 3, 1, 2, 2, 1, "R4");
    push_half(10, 9, 8, 1, 2, 2, 0, "R8");
    push_half(6, 9, 8, 2, 1, 2, 1, "R8");
    push_half(6, 9, 8, 2, 1, 2, 0, "R8");
    push_half(6, 9, 8, 2, 1, 2, 1, "R8");
    goto(24); wr(1, 9);
    goto(54); dbl_mode = 1'b1;
    goto(55); wr(2, 8);
    goto(63); wr(0, 6); wr(3, 2); wr(4, 1);
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nerr++;
      $display("FAIL watchdog expired, queue left=%0d expected 0", q.size());
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule